// File: doc/BRIEF.md
# Bit-masked GPIO port register block

This block is a 32-pin general-purpose I/O port behind a simple 32-bit memory-mapped bus. It keeps an output level and a direction for every pin. It drives the pad output and output-enable signals from those values. It also returns the pad levels, after a two-flop synchronizer, through a read-only register.

Each 32-pin control value is split into two 16-pin registers. The register for pins 0–15 sits at the base offset, and the register for pins 16–31 sits 4 bytes higher. A write carries its own per-bit enable in the upper half of the bus word. Software can therefore change any set of pins in a single write, with no read-modify-write. A constant identification word is also readable.

The bus has a single-cycle write strobe. Reads are requested with a strobe, and the data appears on the next cycle.

Top module: `gpio_mw_port`

## Requirements
- R1: After reset every output-data and direction bit is 0, so `pad_out_o` and `pad_oe_o` are all zero and every control register reads 0.
- R2: A write to the low output-data register (offset 0x00) sets bit i of pins 0–15 to write bit i only where write bit 16+i is 1. Bits whose enable is 0 keep their value.
- R3: The high register of each pair sits 4 bytes above the low one (0x04 for output data, 0x0C for direction). It controls pins 16–31 with the same per-bit enable rule: write bit i goes to pin 16+i when write bit 16+i is 1.
- R4: The direction pair (0x08 low, 0x0C high) drives `pad_oe_o`, where 1 means output. The output-data pair drives `pad_out_o`. Pin n appears on bit n of each.
- R5: A read of any of the four control registers returns its 16 stored bits in bits 15:0 and zero in bits 31:16.
- R6: A read of offset 0x70 returns the synchronized pad inputs, with pin n on bit n. A level sampled on `pad_in_i` at clock edge t can be read by a read strobe at edge t+2 or later. A read at edge t or t+1 still returns the older level.
- R7: A read of offset 0x78 returns the constant 0x0101157C.
- R8: Writes to read-only offsets (0x70, 0x78) or to any unmapped offset, unaligned offsets included, change no state. Reads of unmapped offsets return 0.
- R9: Read data appears on `rdata_o` in the cycle after the read strobe. In any cycle that follows a cycle without a read strobe, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, data follows one cycle later |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write word: bits 31:16 enable, bits 15:0 value |
| rdata_o | output | 32 | Read data |
| pad_in_i | input | 32 | Asynchronous pad input levels |
| pad_out_o | output | 32 | Pad output levels |
| pad_oe_o | output | 32 | Pad output enables, 1 drives the pin |

## Verification
The bench writes words whose enable and value halves differ: partial masks, all-zero masks carrying all-ones values, and masks that clear single bits. A design that ignored the enable, or swapped the two halves, would then show wrong pad levels. It writes the high registers with patterns unlike the low ones, so an offset decode that mixed up the pairs or placed the high half on the wrong pins would be caught. It writes all-ones to read-only, unmapped and unaligned offsets. Aliasing onto a control register would then show up on the pads and in read-back. Back-to-back reads of the input port around a pad change pin down the two-cycle synchronizer delay. A missing stage, or an extra one, shifts which read first shows the new level.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  localparam int ADDR_W   = 8;
  localparam int BUS_W    = 32;
  localparam int HALF_W   = BUS_W / 2;

  localparam logic [ADDR_W-1:0] OFF_DOUT = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_EXT  = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_VER  = 8'h78;

  localparam logic [BUS_W-1:0] VERSION_WORD = 32'h0101_157C;
endpackage

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mw_half_reg.sv
module gpio_mw_half_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [2*W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] bit_en;

  assign bit_en = wdata_i[2*W-1:W];

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b0;
      else if (we_i && bit_en[i]) q[i] <= wdata_i[i];
    end
  end

  assign q_o = q;

  // R2
  masked_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o & ~$past(wdata_i[2*W-1:W])) == ($past(q_o) & ~$past(wdata_i[2*W-1:W]))));

  // R2
  enabled_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o & $past(wdata_i[2*W-1:W])) == ($past(wdata_i[W-1:0]) & $past(wdata_i[2*W-1:W]))));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port
  import gpio_mw_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  localparam int NUM_HALVES = NUM_PINS / HALF_W;

  logic [HALF_W-1:0]   dout_q [NUM_HALVES];
  logic [HALF_W-1:0]   dir_q  [NUM_HALVES];
  logic [NUM_PINS-1:0] pad_sync;
  logic [BUS_W-1:0]    rd_next;
  logic [BUS_W-1:0]    rdata_q;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic dout_we, dir_we;
    assign dout_we = wr_en_i && (addr_i == OFF_DOUT + ADDR_W'(4*h));
    assign dir_we  = wr_en_i && (addr_i == OFF_DIR  + ADDR_W'(4*h));

    gpio_mw_half_reg #(.W(HALF_W)) u_dout (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(dout_we),
      .wdata_i(wdata_i), .q_o(dout_q[h])
    );
    gpio_mw_half_reg #(.W(HALF_W)) u_dir (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(dir_we),
      .wdata_i(wdata_i), .q_o(dir_q[h])
    );

    assign pad_out_o[h*HALF_W +: HALF_W] = dout_q[h];
    assign pad_oe_o[h*HALF_W +: HALF_W]  = dir_q[h];
  end

  gpio_mw_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_in_i), .q_o(pad_sync)
  );

  always_comb begin
    rd_next = '0;
    if (addr_i == OFF_EXT) rd_next = BUS_W'(pad_sync);
    if (addr_i == OFF_VER) rd_next = VERSION_WORD;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (addr_i == OFF_DOUT + ADDR_W'(4*h)) rd_next = {{HALF_W{1'b0}}, dout_q[h]};
      if (addr_i == OFF_DIR  + ADDR_W'(4*h)) rd_next = {{HALF_W{1'b0}}, dir_q[h]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_next;
    else              rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  // R9
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == '0));

  // R7
  version_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_VER) |=> (rdata_o == 32'h0101_157C));

  // R5
  ctrl_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i < 8'h10) |=> (rdata_o[BUS_W-1:HALF_W] == '0));

  // R8
  pads_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pad_out_o) && $stable(pad_oe_o)));
endmodule

// File: tb/sim_gpio_mw_port.sv
`timescale 1ns/1ps
module sim_gpio_mw_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  gpio_mw_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops one expected item per read strobe seen at an edge
  initial begin
    forever begin
      bit pend;
      @(posedge clk);
      pend = rd_en;
      @(negedge clk);
      if (pend && rst_n) begin
        if (exp_q.size() == 0) begin
          chk(rdata, 32'hxxxx_xxxx, "R9 unexpected read");
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(rdata, e, t);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pad_out, 32'h0, "R1 pad_out after reset");
    chk(pad_oe,  32'h0, "R1 pad_oe after reset");
    rd(8'h00, 32'h0, "R1 dout lo reset");
    rd(8'h04, 32'h0, "R1 dout hi reset");
    rd(8'h08, 32'h0, "R1 dir lo reset");
    rd(8'h0C, 32'h0, "R1 dir hi reset");

    wr(8'h00, 32'h00FF_A5A5);
    chk(pad_out, 32'h0000_00A5, "R2 low byte enabled");
    wr(8'h00, 32'hFF00_3C00);
    chk(pad_out, 32'h0000_3CA5, "R2 high byte enabled");
    wr(8'h00, 32'h0000_FFFF);
    chk(pad_out, 32'h0000_3CA5, "R2 zero mask no change");
    rd(8'h00, 32'h0000_3CA5, "R5 dout lo readback");

    wr(8'h04, 32'hF0F0_1234);
    chk(pad_out, 32'h1030_3CA5, "R3 dout hi pins 16-31");
    rd(8'h04, 32'h0000_1030, "R3 R5 dout hi readback");

    wr(8'h08, 32'hFFFF_8001);
    chk(pad_oe, 32'h0000_8001, "R4 dir lo drives oe");
    wr(8'h0C, 32'h0001_FFFF);
    chk(pad_oe, 32'h0001_8001, "R4 R3 dir hi drives oe");
    rd(8'h0C, 32'h0000_0001, "R5 dir hi readback");
    chk(pad_out, 32'h1030_3CA5, "R4 dir write leaves data");

    wr(8'h00, 32'h0001_0000);
    chk(pad_out, 32'h1030_3CA4, "R2 clear single bit");

    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h0A, 32'hFFFF_FFFF);
    chk(pad_out, 32'h1030_3CA4, "R8 ignored writes pad_out");
    chk(pad_oe,  32'h0001_8001, "R8 ignored writes pad_oe");
    rd(8'h78, 32'h0101_157C, "R7 version");
    rd(8'h40, 32'h0, "R8 unmapped read");
    rd(8'h02, 32'h0, "R8 unaligned read");
    rd(8'h08, 32'h0000_8001, "R8 dir lo unchanged");

    @(negedge clk);
    chk(rdata, 32'h0, "R9 idle rdata zero");

    pad_in = 32'h1357_9BDF;
    repeat (4) @(negedge clk);
    rd(8'h70, 32'h1357_9BDF, "R6 settled input");
    pad_in = 32'hDEAD_BEEF;
    rd(8'h70, 32'h1357_9BDF, "R6 read at edge t");
    rd(8'h70, 32'h1357_9BDF, "R6 read at edge t+1");
    rd(8'h70, 32'hDEAD_BEEF, "R6 read at edge t+2");

    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 32'h0, "R9 all reads answered");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule